// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives a single DRAM bank. It takes one access request at a time, each carrying a row address, a column address and a write flag. It turns the request into the activate, read, write and precharge commands the bank needs. It remembers which row is open, and it holds every command back until the minimum spacing since the earlier commands has passed. Each spacing is measured by its own down counter. A configuration pin selects the page policy. With the open-page policy the row stays open after an access, so a later access to that row needs only a column command. With the close-page policy a precharge follows every access on its own.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must keep its request stable. The block never drops or reorders a request. Ready depends only on the internal state and the counters, never on `req_valid`. When the bank is closed, ready stays low until the precharge-to-activate interval has run out. When a row is open and the bank is idle, ready is high. Whenever a request is in progress, ready is low.

Exactly one command is driven per cycle on `cmd_code`. The codes are 0 = no-operation, 1 = activate, 2 = read, 3 = write and 4 = precharge. `cmd_row` and `cmd_col` go with the command and are zero during a no-operation. The block does not move any data. It only pulses `rd_data_valid` at the cycle when read data would return, and `wr_data_due` at the cycle when write data is expected. For every accepted request, `acc_kind` reports whether the access was a closed-bank access, a row hit or a row miss.

Top module: `bank_cmd_sequencer`

## Requirements
- R1: After reset `cmd_code` is 0 (no-operation), `req_ready` is 1, and `rd_data_valid`, `wr_data_due` and `acc_valid` are 0.
- R2: A request accepted while the bank is closed drives activate (code 1) with the request row one cycle after acceptance. It then drives the column command, read (2) or write (3), with the request column exactly T_RCD cycles after the activate.
- R3: `rd_data_valid` is high for exactly one cycle, T_CL cycles after each read command. `wr_data_due` is high for exactly one cycle, T_CWL cycles after each write command.
- R4: Precharge (4) is never driven sooner than T_RAS cycles after the activate of the open row. When a precharge is pending, it is driven in the first cycle that rule allows, and in no case earlier than one cycle after the decision.
- R5: Activate is never driven sooner than T_RP cycles after a precharge. An activate that waits only on that rule is driven exactly T_RP cycles after the precharge.
- R6: Under the open-page policy (`close_page`=0), a request to the open row drives only its column command, one cycle after acceptance, and the row stays open.
- R7: Under the open-page policy, a request to a different row drives precharge, then activate of the new row T_RP cycles later, then the column command T_RCD cycles after that.
- R8: Under the close-page policy (`close_page`=1), every column command is followed by a precharge at the later of the next cycle and T_RAS after the activate. The next request is then handled as a closed-bank access.
- R9: `req_ready` is low while a request is in progress. In the closed state it stays low until T_RP-1 cycles after a precharge. In the open idle state it is high.
- R10: One cycle after each acceptance, `acc_valid` pulses once and `acc_kind` gives 0 for a closed-bank access, 1 for a row hit or 2 for a row miss. `acc_valid` is 0 in every other cycle.
- R11: `cmd_code` carries only the codes 0 to 4, and every cycle without a command carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| close_page | input | 1 | Page policy: 1 = close page, 0 = open page |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_row | input | ROW_W | Request row address |
| req_col | input | COL_W | Request column address |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_code | output | 3 | Command code this cycle |
| cmd_row | output | ROW_W | Row address of the command |
| cmd_col | output | COL_W | Column address of the command |
| rd_data_valid | output | 1 | Read data would be on the bus this cycle |
| wr_data_due | output | 1 | Write data is expected this cycle |
| acc_valid | output | 1 | Access kind report strobe |
| acc_kind | output | 2 | 0 closed, 1 hit, 2 miss |

## Verification
The hardest case to reach from the ports is a row miss that arrives while the row-active interval of the current row is still running. The precharge must then wait for that counter and not follow the request at once. To reach it, the bench sends each miss a chosen number of cycles after the previous column command, sweeping that gap from zero up past T_RAS. Each sweep step starts from the row opened by the step before, so both the delayed precharges and the immediate ones are covered. The bench predicts every command cycle as the maximum of the two bounds.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } bank_cmd_e;

  typedef enum logic [1:0] {
    ACC_CLOSED = 2'd0,
    ACC_HIT    = 2'd1,
    ACC_MISS   = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_CLOSED   = 3'd0,
    ST_OPEN     = 3'd1,
    ST_ACT_WAIT = 3'd2,
    ST_PRE_WAIT = 3'd3,
    ST_RP_WAIT  = 3'd4
  } bank_state_e;

  localparam int NUM_TIMERS = 3;
  localparam int TMR_RCD    = 0;
  localparam int TMR_RAS    = 1;
  localparam int TMR_RP     = 2;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/bank_interval_timer.sv
module bank_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/bank_latency_line.sv
module bank_latency_line #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (LAT == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [LAT-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[LAT-2:0], din};
      end
      assign dout = sr[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/bank_seq_fsm.sv
module bank_seq_fsm
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 15,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_page,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  logic             rcd_done,
  input  logic             ras_done,
  input  logic             rp_done,
  output logic             ld_act,
  output logic             ld_pre,
  output logic [2:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             acc_valid,
  output logic [1:0]       acc_kind
);

  bank_state_e      st_q, st_n;
  bank_cmd_e        cmd_q, cmd_n;
  acc_kind_e        kind_q, kind_n;
  logic [ROW_W-1:0] row_q, row_n, open_row_q, pend_row_q;
  logic [COL_W-1:0] col_q, col_n, pend_col_q;
  logic             pend_wr_q, auto_q, auto_n, take, accv_q;

  always_comb begin
    st_n      = st_q;
    cmd_n     = CMD_NOP;
    row_n     = '0;
    col_n     = '0;
    take      = 1'b0;
    kind_n    = ACC_CLOSED;
    auto_n    = auto_q;
    req_ready = 1'b0;
    case (st_q)
      ST_CLOSED: begin
        req_ready = rp_done;
        if (req_valid && rp_done) begin
          take   = 1'b1;
          kind_n = ACC_CLOSED;
          cmd_n  = CMD_ACT;
          row_n  = req_row;
          st_n   = ST_ACT_WAIT;
        end
      end
      ST_OPEN: begin
        req_ready = 1'b1;
        if (req_valid) begin
          take = 1'b1;
          if (req_row == open_row_q) begin
            kind_n = ACC_HIT;
            cmd_n  = req_write ? CMD_WR : CMD_RD;
            row_n  = req_row;
            col_n  = req_col;
            if (close_page) begin
              st_n   = ST_PRE_WAIT;
              auto_n = 1'b1;
            end
          end else begin
            kind_n = ACC_MISS;
            auto_n = 1'b0;
            if (ras_done) begin
              cmd_n = CMD_PRE;
              row_n = open_row_q;
              st_n  = ST_RP_WAIT;
            end else begin
              st_n = ST_PRE_WAIT;
            end
          end
        end
      end
      ST_ACT_WAIT: begin
        if (rcd_done) begin
          cmd_n = pend_wr_q ? CMD_WR : CMD_RD;
          row_n = pend_row_q;
          col_n = pend_col_q;
          if (close_page) begin
            st_n   = ST_PRE_WAIT;
            auto_n = 1'b1;
          end else begin
            st_n = ST_OPEN;
          end
        end
      end
      ST_PRE_WAIT: begin
        if (ras_done) begin
          cmd_n = CMD_PRE;
          row_n = open_row_q;
          st_n  = auto_q ? ST_CLOSED : ST_RP_WAIT;
        end
      end
      ST_RP_WAIT: begin
        if (rp_done) begin
          cmd_n = CMD_ACT;
          row_n = pend_row_q;
          st_n  = ST_ACT_WAIT;
        end
      end
      default: st_n = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_CLOSED;
      cmd_q      <= CMD_NOP;
      row_q      <= '0;
      col_q      <= '0;
      kind_q     <= ACC_CLOSED;
      accv_q     <= 1'b0;
      auto_q     <= 1'b0;
      open_row_q <= '0;
      pend_row_q <= '0;
      pend_col_q <= '0;
      pend_wr_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cmd_q  <= cmd_n;
      row_q  <= row_n;
      col_q  <= col_n;
      auto_q <= auto_n;
      accv_q <= take;
      if (take) begin
        kind_q     <= kind_n;
        pend_row_q <= req_row;
        pend_col_q <= req_col;
        pend_wr_q  <= req_write;
      end
      if (cmd_n == CMD_ACT) open_row_q <= row_n;
    end
  end

  assign ld_act    = (cmd_n == CMD_ACT);
  assign ld_pre    = (cmd_n == CMD_PRE);
  assign cmd_code  = cmd_q;
  assign cmd_row   = row_q;
  assign cmd_col   = col_q;
  assign acc_valid = accv_q;
  assign acc_kind  = kind_q;

endmodule

// File: rtl/bank_cmd_sequencer.sv
module bank_cmd_sequencer
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 15,
  parameter int COL_W = 10,
  parameter int T_RCD = 30,
  parameter int T_CL  = 30,
  parameter int T_CWL = 28,
  parameter int T_RP  = 30,
  parameter int T_RAS = 75
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_page,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  output logic [2:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_data_valid,
  output logic             wr_data_due,
  output logic             acc_valid,
  output logic [1:0]       acc_kind
);

  localparam int CNT_W = $clog2(max3(T_RCD, T_RAS, T_RP) + 1);

  logic                 ld_act, ld_pre;
  logic [NUM_TIMERS-1:0] t_load, t_done;
  logic [CNT_W-1:0]     t_val [NUM_TIMERS];

  always_comb begin
    t_load          = '0;
    t_load[TMR_RCD] = ld_act;
    t_load[TMR_RAS] = ld_act;
    t_load[TMR_RP]  = ld_pre;
    t_val[TMR_RCD]  = CNT_W'(T_RCD - 1);
    t_val[TMR_RAS]  = CNT_W'(T_RAS - 1);
    t_val[TMR_RP]   = CNT_W'(T_RP - 1);
  end

  generate
    for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_tmr
      bank_interval_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load[gi]),
        .load_val (t_val[gi]),
        .done     (t_done[gi])
      );
    end
  endgenerate

  bank_seq_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .close_page (close_page),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_write  (req_write),
    .rcd_done   (t_done[TMR_RCD]),
    .ras_done   (t_done[TMR_RAS]),
    .rp_done    (t_done[TMR_RP]),
    .ld_act     (ld_act),
    .ld_pre     (ld_pre),
    .cmd_code   (cmd_code),
    .cmd_row    (cmd_row),
    .cmd_col    (cmd_col),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind)
  );

  bank_latency_line #(.LAT(T_CL)) u_rd_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cmd_code == CMD_RD),
    .dout  (rd_data_valid)
  );

  bank_latency_line #(.LAT(T_CWL)) u_wr_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cmd_code == CMD_WR),
    .dout  (wr_data_due)
  );

endmodule

// File: rtl/bank_seq_checker.sv
module bank_seq_checker #(
  parameter int T_RCD = 30,
  parameter int T_RP  = 30,
  parameter int T_RAS = 75
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] cmd_code,
  input logic       acc_valid,
  input logic [1:0] acc_kind
);

  localparam int SAT = 1 << 20;

  int since_act, since_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_pre <= SAT;
    end else begin
      if (cmd_code == 3'd1)  since_act <= 1;
      else if (since_act < SAT) since_act <= since_act + 1;
      if (cmd_code == 3'd4)  since_pre <= 1;
      else if (since_pre < SAT) since_pre <= since_pre + 1;
    end
  end

  p_col_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd2 || cmd_code == 3'd3) |-> since_act >= T_RCD);

  p_pre_after_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd4) |-> since_act >= T_RAS);

  p_act_after_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd1) |-> since_pre >= T_RP);

  p_hit_column_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd1) |-> (cmd_code == 3'd2 || cmd_code == 3'd3));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd1) |-> !req_ready);

  p_acc_follows_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> acc_valid);

  p_acc_only_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !acc_valid);

  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code <= 3'd4);

endmodule

bind bank_cmd_sequencer bank_seq_checker #(
  .T_RCD (T_RCD),
  .T_RP  (T_RP),
  .T_RAS (T_RAS)
) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_code  (cmd_code),
  .acc_valid (acc_valid),
  .acc_kind  (acc_kind)
);

// File: tb/bank_cmd_sequencer_bench.sv
module bank_cmd_sequencer_bench;

  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int TRCD  = 3;
  localparam int TCL   = 4;
  localparam int TCWL  = 2;
  localparam int TRP   = 2;
  localparam int TRAS  = 7;
  localparam int HN    = 2048;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             close_page = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_write = 1'b0;
  logic [2:0]       cmd_code;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             rd_data_valid, wr_data_due, acc_valid;
  logic [1:0]       acc_kind;

  bank_cmd_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(TRCD), .T_CL(TCL),
    .T_CWL(TCWL), .T_RP(TRP), .T_RAS(TRAS)
  ) u_bank_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .close_page(close_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
    .req_col(req_col), .req_write(req_write), .cmd_code(cmd_code),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_data_valid(rd_data_valid),
    .wr_data_due(wr_data_due), .acc_valid(acc_valid), .acc_kind(acc_kind)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [2:0]       h_cmd  [0:HN-1];
  logic [ROW_W-1:0] h_row  [0:HN-1];
  logic [COL_W-1:0] h_col  [0:HN-1];
  logic [1:0]       h_kind [0:HN-1];
  logic             h_rdy  [0:HN-1];
  logic             h_rdv  [0:HN-1];
  logic             h_wrd  [0:HN-1];
  logic             h_accv [0:HN-1];
  int bad_codes = 0;

  always @(negedge clk) begin
    if (cyc < HN) begin
      h_cmd[cyc]  = cmd_code;
      h_row[cyc]  = cmd_row;
      h_col[cyc]  = cmd_col;
      h_kind[cyc] = acc_kind;
      h_rdy[cyc]  = req_ready;
      h_rdv[cyc]  = rd_data_valid;
      h_wrd[cyc]  = wr_data_due;
      h_accv[cyc] = acc_valid;
    end
    if (rst_n && cmd_code > 3'd4) bad_codes = bad_codes + 1;
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic chk_eq(input int act, input int exp, input string what);
    chk(act == exp, what, act, exp);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int count_cmds(input int from, input int to);
    int n = 0;
    for (int t = from; t <= to; t++) if (h_cmd[t] != 3'd0) n++;
    return n;
  endfunction

  task automatic send(input int row, input int col, input bit wr, output int acc);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    req_write = wr;
    acc       = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, h, c, act, col, pre, act_cur, row_cur, rowx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_eq(cmd_code, 0, "R1 cmd after reset");
    chk_eq(req_ready, 1, "R1 ready after reset");
    chk_eq(rd_data_valid | wr_data_due | acc_valid, 0, "R1 strobes after reset");

    // R2 closed-bank read, R3 read strobe, R10 closed kind
    send(3, 5, 1'b0, a);
    wait_until(a + 20);
    act = a + 1;
    col = act + TRCD;
    chk_eq(h_cmd[act], 1, "R2 activate cycle");
    chk_eq(h_row[act], 3, "R2 activate row");
    chk_eq(h_cmd[col], 2, "R2 read after T_RCD");
    chk_eq(h_col[col], 5, "R2 read column");
    chk_eq(h_rdv[col + TCL], 1, "R3 read valid at T_CL");
    chk_eq(h_rdv[col + TCL - 1] | h_rdv[col + TCL + 1], 0, "R3 read valid single pulse");
    chk_eq(h_accv[act], 1, "R10 acc_valid after accept");
    chk_eq(h_kind[act], 0, "R10 closed kind");
    chk_eq(h_rdy[act + 1], 0, "R9 ready low while busy");
    chk_eq(count_cmds(a + 1, a + 19), 2, "R11 command count closed access");
    act_cur = act;

    // R6 open-page hit write, R3 write strobe
    send(3, 2, 1'b1, b);
    wait_until(b + 15);
    chk_eq(h_cmd[b + 1], 3, "R6 hit write command");
    chk_eq(h_col[b + 1], 2, "R6 hit write column");
    chk_eq(count_cmds(b + 1, b + 14), 1, "R6 hit issues only column");
    chk_eq(h_wrd[b + 1 + TCWL], 1, "R3 write due at T_CWL");
    chk_eq(h_wrd[b + TCWL] | h_wrd[b + 2 + TCWL], 0, "R3 write due single pulse");
    chk_eq(h_kind[b + 1], 1, "R10 hit kind");
    chk_eq(h_rdy[b + 1], 1, "R9 ready high in open idle");

    // R7 miss sweep over gap to previous column command (R4, R5)
    // open a fresh row so the row-active counter is running
    send(8, 0, 1'b0, a);
    wait_until(a + 2);
    // bank open at row 3: this is a miss; finish it first
    pre = imax(a + 1, act_cur + TRAS);
    act_cur = pre + TRP;
    row_cur = 8;
    wait_until(act_cur + TRCD + 1);
    chk_eq(h_cmd[act_cur + TRCD], 2, "R7 initial miss column");
    for (int g = 0; g <= TRAS; g++) begin
      repeat (g) @(negedge clk);
      rowx = (row_cur == 6) ? 9 : 6;
      send(rowx, g, 1'b0, a);
      pre = imax(a + 1, act_cur + TRAS);
      act = pre + TRP;
      col = act + TRCD;
      wait_until(col + 1);
      chk_eq(h_cmd[pre], 4, $sformatf("R4 precharge at earliest cycle gap %0d", g));
      chk_eq(h_row[pre], row_cur, "R7 precharge row");
      chk_eq(h_cmd[act], 1, $sformatf("R5 activate T_RP after precharge gap %0d", g));
      chk_eq(h_row[act], rowx, "R7 activate new row");
      chk_eq(h_cmd[col], 2, "R7 column after activate");
      chk_eq(h_col[col], g, "R7 column address");
      chk_eq(h_kind[a + 1], 2, "R10 miss kind");
      chk_eq(count_cmds(a + 1, col), 3, "R11 command count miss");
      act_cur = act;
      row_cur = rowx;
    end

    // R8 close-page: hit then auto precharge
    close_page = 1'b1;
    repeat (2) @(negedge clk);
    send(row_cur, 1, 1'b0, h);
    pre = imax(h + 2, act_cur + TRAS);
    wait_until(pre + TRP + 2);
    chk_eq(h_cmd[h + 1], 2, "R8 hit read under close page");
    chk_eq(h_kind[h + 1], 1, "R10 hit kind close page");
    chk_eq(h_cmd[pre], 4, "R8 auto precharge after hit");
    chk_eq(h_rdy[pre], 0, "R9 ready low during T_RP");
    chk_eq(h_rdy[pre + TRP - 1], 1, "R9 ready back after T_RP");
    chk_eq(h_rdv[h + 1 + TCL], 1, "R3 read valid close page");

    // R8 same row again is a closed-bank access
    send(row_cur, 4, 1'b1, c);
    act = c + 1;
    col = act + TRCD;
    pre = imax(col + 1, act + TRAS);
    wait_until(pre + TRP + 2);
    chk_eq(h_kind[c + 1], 0, "R8 next access closed kind");
    chk_eq(h_cmd[act], 1, "R8 activate after auto precharge");
    chk_eq(h_cmd[col], 3, "R2 write after T_RCD");
    chk_eq(h_wrd[col + TCWL], 1, "R3 write due close page");
    chk_eq(h_cmd[pre], 4, "R8 auto precharge after T_RAS");
    chk_eq(count_cmds(c + 1, pre + TRP), 3, "R11 command count close page");
    chk_eq(bad_codes, 0, "R11 illegal command codes");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule